// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers eight active-high, level-sensitive interrupt request lines, numbered 0 to 7. It filters them through a per-line mask and picks the pending line with the lowest number. It then signals the processor on a single interrupt output. Line 0 outranks all others and cannot be masked. When the processor accepts the interrupt with a one-cycle acknowledge pulse, the controller records the chosen line as in service. In the following cycle it places an 8-bit vector on the read data bus. The vector is a programmable 5-bit base followed by the 3-bit line number.

An in-service line holds back every request of equal or lower rank. A request of higher rank still interrupts, so service can nest. Software ends a service by writing the first control register with the end-of-service bit set. That write retires the highest-ranked in-service line and lets deferred requests through.

Configuration uses a small register port with a select, read and write strobes, one address bit and an 8-bit write bus. The vector path has no back-pressure. The vector appears in the cycle after an accepted acknowledge and stays on the bus for as long as the read strobe is held. When the read strobe drops, the bus returns to normal register reads. All outputs change only after rising clock edges.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `int_out` is 0, the in-service set is empty, the mask register holds 8'hFF, the vector base is 0, and `rdata` is 0 while no register is read.
- R2: Line 0 raises `int_out` whenever it is pending and line 0 is not in service, whatever the value of mask bit 0.
- R3: A line 1 to 7 whose mask bit is 1 never raises `int_out`.
- R4: Among unmasked pending lines, the lowest-numbered one is selected, and its number forms `rdata[2:0]` of the vector.
- R5: An `ack` pulse is accepted only in a cycle where `int_out` is 1. An `ack` in any other cycle changes nothing visible at the ports.
- R6: In the cycle after an accepted `ack`, `rdata` equals {base, line number}. It keeps that value while `rd` stays 1 and falls back to normal read data once `rd` is 0.
- R7: While a line is in service, a pending line of equal or lower rank leaves `int_out` at 0, and a pending line of higher rank sets it to 1.
- R8: A write to address 0 with `wdata[5]` = 1 clears only the lowest-numbered in-service line, which releases requests that were deferred behind it.
- R9: A write to address 0 with `wdata[5]` = 0 loads `wdata` into the mask (bit i = 1 masks line i). A write to address 1 loads `wdata[7:3]` as the base. With `sel` and `rd` set and no vector shown, address 0 reads the mask and address 1 reads {base, 3'b000}.
- R10: A request line is registered once before it is used, so `int_out` responds one cycle after `irq_in` changes. Accepting a line drops its request for one cycle, after which the level is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Level request lines, bit i is line i |
| sel | input | 1 | Register port select |
| rd | input | 1 | Read strobe, also holds the vector on the bus |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Chooses control register 0 or 1 |
| wdata | input | 8 | Write data |
| ack | input | 1 | One-cycle interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| rdata | output | 8 | Register read data or the interrupt vector |

## Verification
A corrupted in-service set shows up at once on `int_out`. A stale bit blocks a later request of equal rank, and a missing bit lets a lower-ranked request interrupt in the same cycle the request is registered. A wrong priority encode or base register shows at `rdata` one cycle after the acknowledge. A mask fault shows one cycle after the request edge. Because the reference model is compared against both outputs on every cycle, any such divergence is reported in the first cycle it reaches a port, not at the end of a scenario.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_LINES = 8;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int DATA_W    = 8;
  localparam int BASE_W    = DATA_W - IDX_W;
  localparam int EOI_BIT   = 5;

  typedef logic [NUM_LINES-1:0] line_t;
  typedef logic [IDX_W-1:0]     idx_t;
  typedef logic [BASE_W-1:0]    base_t;
  typedef logic [DATA_W-1:0]    byte_t;

  localparam line_t UNMASKABLE = line_t'(1);
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  wr,
  input  logic  addr,
  input  byte_t wdata,
  output line_t mask_q,
  output base_t base_q,
  output logic  eoi
);
  logic wr_ctl0;
  logic wr_ctl1;

  assign wr_ctl0 = sel & wr & ~addr;
  assign wr_ctl1 = sel & wr & addr;
  assign eoi     = wr_ctl0 & wdata[EOI_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
    end else begin
      if (wr_ctl0 && !wdata[EOI_BIT]) mask_q <= line_t'(wdata);
      if (wr_ctl1) base_q <= wdata[DATA_W-1:IDX_W];
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_t irq_in,
  input  line_t mask_q,
  input  base_t base_q,
  input  logic  ack,
  input  logic  rd,
  input  logic  eoi,
  output line_t req_q,
  output line_t isr_q,
  output logic  int_out,
  output logic  vec_show,
  output byte_t vec_q
);
  line_t pend;
  logic  p_any;
  idx_t  p_idx;
  logic  s_any;
  idx_t  s_idx;
  logic  take;
  line_t take_bit;
  line_t eoi_bit;

  assign pend = req_q & ~(mask_q & ~UNMASKABLE);

  intc_first_set #(.N(NUM_LINES), .W(IDX_W)) u_pend_pick (
    .bits (pend),
    .found(p_any),
    .idx  (p_idx)
  );

  intc_first_set #(.N(NUM_LINES), .W(IDX_W)) u_isr_pick (
    .bits (isr_q),
    .found(s_any),
    .idx  (s_idx)
  );

  assign int_out  = p_any && (!s_any || (p_idx < s_idx));
  assign take     = ack & int_out;
  assign take_bit = take ? (line_t'(1) << p_idx) : '0;
  assign eoi_bit  = (eoi && s_any) ? (line_t'(1) << s_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      isr_q    <= '0;
      vec_show <= 1'b0;
      vec_q    <= '0;
    end else begin
      req_q    <= irq_in & ~take_bit;
      isr_q    <= (isr_q & ~eoi_bit) | take_bit;
      vec_show <= take | (vec_show & rd);
      if (take) vec_q <= {base_q, p_idx};
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       ack,
  output logic       int_out,
  output logic [7:0] rdata
);
  line_t mask_q;
  base_t base_q;
  logic  eoi;
  line_t req_q;
  line_t isr_q;
  logic  vec_show;
  byte_t vec_q;

  intc_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr    (wr),
    .addr  (addr),
    .wdata (wdata),
    .mask_q(mask_q),
    .base_q(base_q),
    .eoi   (eoi)
  );

  intc_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .base_q  (base_q),
    .ack     (ack),
    .rd      (rd),
    .eoi     (eoi),
    .req_q   (req_q),
    .isr_q   (isr_q),
    .int_out (int_out),
    .vec_show(vec_show),
    .vec_q   (vec_q)
  );

  always_comb begin
    if (vec_show)        rdata = vec_q;
    else if (sel && rd)  rdata = addr ? {base_q, {IDX_W{1'b0}}} : mask_q;
    else                 rdata = '0;
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       int_out,
  input logic [7:0] rdata,
  input logic [7:0] req_q,
  input logic [7:0] isr_q,
  input logic [7:0] mask_q
);
  AST_LINE0_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[0] && !isr_q[0]) |-> int_out); // R2

  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((req_q & {~mask_q[7:1], 1'b1}) != 8'h00)); // R3

  AST_VECTOR_NAMES_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out) |=> isr_q[rdata[2:0]]); // R6

  AST_ISR_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(isr_q) > $countones($past(isr_q))) |-> $past(ack && int_out)); // R5

  AST_EOI_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(isr_q)) <= $countones(isr_q) + 1)); // R8
endmodule

bind prio_vec_intc intc_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ack    (ack),
  .int_out(int_out),
  .rdata  (rdata),
  .req_q  (req_q),
  .isr_q  (isr_q),
  .mask_q (mask_q)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       sel, rd, wr, addr, ack;
  logic [7:0] wdata;
  logic       int_out;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  prio_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sel(sel), .rd(rd),
    .wr(wr), .addr(addr), .wdata(wdata), .ack(ack),
    .int_out(int_out), .rdata(rdata)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_req, m_mask, m_isr, m_vec;
  logic [4:0] m_base;
  logic       m_show;

  function automatic int first_one(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    logic [7:0] live;
    live = m_req & ~(m_mask & 8'hFE);
    return (live != 0) && (first_one(live) < first_one(m_isr));
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (m_show) return m_vec;
    if (sel && rd) return addr ? {m_base, 3'b000} : m_mask;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_mask = 8'hFF; m_isr = 0; m_vec = 0; m_base = 0; m_show = 0;
    end else begin
      logic       acc;
      int         hp;
      int         hs;
      logic [7:0] newisr;
      hp  = first_one(m_req & ~(m_mask & 8'hFE));
      hs  = first_one(m_isr);
      acc = ack && exp_int();
      newisr = m_isr;
      if (sel && wr && !addr && wdata[5] && hs < 8) newisr[hs] = 1'b0;
      if (acc) begin
        newisr[hp] = 1'b1;
        m_vec = {m_base, 3'(hp)};
      end
      m_show = acc || (m_show && rd);
      if (sel && wr && !addr && !wdata[5]) m_mask = wdata;
      if (sel && wr && addr) m_base = wdata[7:3];
      m_isr = newisr;
      m_req = irq_in;
      if (acc) m_req[hp] = 1'b0;
    end
  end

  task automatic check(string r, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(cur_req, {7'd0, int_out}, {7'd0, exp_int()}, "int_out");
      check(cur_req, rdata, exp_rdata(), "rdata");
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d; tick(); sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic rd_reg(logic a);
    sel = 1; rd = 1; addr = a; tick(); sel = 0; rd = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; irq_in = 0; sel = 0; rd = 0; wr = 0; addr = 0; ack = 0; wdata = 0;
    tick(3);
    // R1: reset state seen at the ports
    check("R1", {7'd0, int_out}, 8'h00, "int_out in reset");
    check("R1", rdata, 8'h00, "rdata in reset");
    rst_n = 1; tick();
    cur_req = "R1"; rd_reg(0); rd_reg(1); tick();

    cur_req = "R9";
    wr_reg(1, 8'hA8);          // base 5'h15
    wr_reg(0, 8'h00);          // unmask all
    rd_reg(0); rd_reg(1); tick();

    cur_req = "R5";            // ack with no interrupt pending
    pulse_ack(); tick(2);

    cur_req = "R10";
    irq_in = 8'b0110_0000; tick(2);
    cur_req = "R4";
    pulse_ack();
    cur_req = "R6";
    rd = 1; tick(3); rd = 0; tick(2);

    cur_req = "R7";            // line 6 pending behind line 5, line 2 preempts
    tick(2);
    irq_in = 8'b0110_0100; tick(2);
    pulse_ack(); rd = 1; tick(); rd = 0; tick(2);

    cur_req = "R8";
    wr_reg(0, 8'h20); tick(2); // retires line 2
    wr_reg(0, 8'h20); tick(2); // retires line 5, line 6 released
    irq_in = 8'b0100_0000;
    pulse_ack(); tick(2);
    wr_reg(0, 8'h20); tick(2);
    irq_in = 0; tick(3);

    cur_req = "R3";
    wr_reg(0, 8'hDF); tick();  // mask all but line 5 and forced line 0
    irq_in = 8'b1101_1110; tick(4);
    cur_req = "R2";
    irq_in = 8'b1101_1111; tick(2);
    pulse_ack(); rd = 1; tick(); rd = 0; tick(2);
    cur_req = "R7";
    pulse_ack(); tick(2);      // line 0 in service: nothing outranks it
    cur_req = "R8";
    wr_reg(0, 8'h20); tick(3);
    irq_in = 0; tick(2);
    cur_req = "R4";
    wr_reg(0, 8'h00);
    irq_in = 8'b1000_1000; tick(2);
    pulse_ack(); rd = 1; tick(2); rd = 0;
    wr_reg(0, 8'h20); tick(2);
    irq_in = 0; tick(3);
    finish_run();
  end
endmodule